// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block takes one high-level flash request at a time and carries it out as a series of serial transactions on a single chip-select line. The supported requests are identification read, status read, data read, 4 KB sector erase and page program. The requester does not handle opcodes or polling. For the two operations that change the array, the block first sends a write-enable transaction on its own. It then sends the command with a three-byte address. Finally it reads the status register repeatedly until the device reports idle.

The requester sees a ready/valid handshake, a one-byte pull interface for program payload (`wr_take` pulses each time a byte is consumed, and the next byte must then be presented), a one-byte push interface for returned data, and a completion pulse with an error code. The serial side is a built-in Mode 0 shifter. Each SCLK half period lasts `DIV` clock cycles.

Top module: `spi_nor_sequencer`

## Requirements
- R1: SPI framing is Mode 0, MSB first, in 8-bit frames. `spi_sclk` is low whenever `spi_cs_n` is high. `spi_mosi` changes only while `spi_sclk` is low. `spi_miso` is taken at each rising edge.
- R2: Request code 0 (identify) sends opcode 0x9F, then clocks in exactly three bytes under one chip-select. Each of the three bytes is delivered on `rd_data` with a `rd_valid` pulse.
- R3: Request code 1 (status) sends opcode 0x05 and returns one byte on `rd_data`. The transaction is two bytes long.
- R4: Request code 2 (read) sends opcode 0x03, then the 24-bit `req_addr` as three bytes, high byte first. It then streams `req_len` bytes to `rd_data`, all under one chip-select.
- R5: Request code 3 (erase) first runs a one-byte 0x06 transaction. Chip-select then goes high. A second transaction sends 0x20 and the three address bytes.
- R6: Request code 4 (program) runs the 0x06 transaction. It then sends 0x02, the three address bytes and `req_len` payload bytes taken from `wr_data`, with exactly one `wr_take` pulse per payload byte.
- R7: A program request with `req_len` above `PAGE_BYTES` (256) is answered in the cycle after acceptance with `done`, `err` and `err_code` = 1, with no chip-select activity. A request of exactly 256 bytes is carried out.
- R8: After an erase or a program, the block repeats two-byte 0x05 transactions, with chip-select high between them, until bit 0 of the status byte is 0. It then pulses `done` with `err` low.
- R9: When `POLL_LIMIT` is nonzero and that many status reads in a row all show bit 0 set, the block ends with `done`, `err` and `err_code` = 2.
- R10: `req_ready` is high only when the block is idle, and a request held while it is low is not taken. `done` is high only together with `req_ready`, so a request presented in the `done` cycle is accepted at once.
- R11: Request codes 5 to 7 are answered with `done`, `err` and `err_code` = 3, with no bus activity.
- R12: After reset, `req_ready` is 1, `spi_cs_n` is 1, `spi_sclk` is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_op | input | 3 | Request code: 0 identify, 1 status, 2 read, 3 erase, 4 program |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W | Payload or read byte count |
| wr_data | input | 8 | Current program payload byte |
| wr_take | output | 1 | Payload byte consumed, present the next one |
| rd_data | output | 8 | Returned byte |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| done | output | 1 | Request finished (one-cycle pulse) |
| err | output | 1 | Request ended in error, valid with `done` |
| err_code | output | 2 | 1 too long, 2 poll timeout, 3 bad request code |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Completion of one request and acceptance of the next can happen in the same cycle. `done` rises in the first idle cycle, so a `req_valid` held high during that cycle is taken immediately. The bench provokes this by holding a second request on `req_valid` for the whole of a status read. It then checks three things: the second request was ignored while `req_ready` was low, it was accepted exactly on the `done` cycle, and the flash model logs both transactions in order with the right returned bytes. A per-clock reference tracks the expected `req_ready` and serial idle levels on every cycle.

// File: rtl/spi_nor_sequencer.sv
`timescale 1ns/1ps
module spi_nor_sequencer #(
  parameter int DIV        = 2,
  parameter int LEN_W      = 12,
  parameter int PAGE_BYTES = 256,
  parameter int POLL_LIMIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             err,
  output logic [1:0]       err_code,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int DIV_W  = $clog2(DIV + 1);
  localparam int TOT_W  = LEN_W + 3;
  localparam int POLL_W = (POLL_LIMIT > 0) ? $clog2(POLL_LIMIT + 1) : 1;

  localparam logic [2:0] OP_ID = 3'd0, OP_STAT = 3'd1, OP_READ = 3'd2,
                         OP_ERASE = 3'd3, OP_PROG = 3'd4;
  localparam logic [7:0] CMD_RDID = 8'h9F, CMD_RDSR = 8'h05, CMD_WREN = 8'h06,
                         CMD_PP = 8'h02, CMD_SE = 8'h20, CMD_READ = 8'h03;

  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD, ST_GAP} state_t;
  typedef enum logic [1:0] {SG_WEN, SG_MAIN, SG_POLL} stage_t;

  state_t            state;
  stage_t            stage;
  logic [2:0]        op_q;
  logic [23:0]       addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [DIV_W-1:0]  hcnt;
  logic              tick, sclk_q, busy_q;
  logic [2:0]        bcnt;
  logic [TOT_W-1:0]  bidx, nidx, x_tot;
  logic [7:0]        tx_sh, rx_sh, x_code, nxt_byte;
  logic [2:0]        x_hdr;
  logic              x_rd, x_wr;
  logic [POLL_W-1:0] pcnt;
  logic              writes_flash, req_fire, bad_op, bad_len;

  assign tick         = (hcnt == DIV_W'(DIV - 1));
  assign req_ready    = (state == ST_IDLE);
  assign req_fire     = req_valid && req_ready;
  assign bad_op       = (req_op > OP_PROG);
  assign bad_len      = (req_op == OP_PROG) && (int'(req_len) > PAGE_BYTES);
  assign writes_flash = (op_q == OP_ERASE) || (op_q == OP_PROG);
  assign spi_cs_n     = (state == ST_IDLE) || (state == ST_GAP);
  assign spi_sclk     = sclk_q;
  assign spi_mosi     = tx_sh[7] & ~spi_cs_n;
  assign nidx         = bidx + TOT_W'(1);

  always_comb begin
    x_code = CMD_RDSR;
    x_hdr  = 3'd1;
    x_tot  = TOT_W'(1);
    x_rd   = 1'b0;
    x_wr   = 1'b0;
    case (stage)
      SG_WEN:  x_code = CMD_WREN;
      SG_POLL: begin x_code = CMD_RDSR; x_tot = TOT_W'(2); end
      default: begin
        case (op_q)
          OP_ID:    begin x_code = CMD_RDID; x_tot = TOT_W'(4); x_rd = 1'b1; end
          OP_STAT:  begin x_code = CMD_RDSR; x_tot = TOT_W'(2); x_rd = 1'b1; end
          OP_READ:  begin x_code = CMD_READ; x_hdr = 3'd4; x_rd = 1'b1;
                          x_tot = TOT_W'(len_q) + TOT_W'(4); end
          OP_ERASE: begin x_code = CMD_SE; x_hdr = 3'd4; x_tot = TOT_W'(4); end
          default:  begin x_code = CMD_PP; x_hdr = 3'd4; x_wr = 1'b1;
                          x_tot = TOT_W'(len_q) + TOT_W'(4); end
        endcase
      end
    endcase
  end

  always_comb begin
    if (nidx < TOT_W'(x_hdr)) begin
      case (nidx[1:0])
        2'd1:    nxt_byte = addr_q[23:16];
        2'd2:    nxt_byte = addr_q[15:8];
        default: nxt_byte = addr_q[7:0];
      endcase
    end else begin
      nxt_byte = x_wr ? wr_data : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      stage    <= SG_MAIN;
      op_q     <= '0;
      addr_q   <= '0;
      len_q    <= '0;
      hcnt     <= '0;
      sclk_q   <= 1'b0;
      bcnt     <= '0;
      bidx     <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      busy_q   <= 1'b0;
      pcnt     <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      err_code <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      wr_take  <= 1'b0;
    end else begin
      done     <= 1'b0;
      err      <= 1'b0;
      err_code <= '0;
      rd_valid <= 1'b0;
      wr_take  <= 1'b0;
      hcnt     <= (state == ST_IDLE || tick) ? '0 : hcnt + DIV_W'(1);
      case (state)
        ST_IDLE: if (req_valid) begin
          if (bad_op || bad_len) begin
            done     <= 1'b1;
            err      <= 1'b1;
            err_code <= bad_op ? 2'd3 : 2'd1;
          end else begin
            op_q   <= req_op;
            addr_q <= req_addr;
            len_q  <= req_len;
            stage  <= (req_op == OP_ERASE || req_op == OP_PROG) ? SG_WEN : SG_MAIN;
            pcnt   <= '0;
            state  <= ST_SETUP;
          end
        end
        ST_SETUP: if (tick) begin
          tx_sh <= x_code;
          bidx  <= '0;
          bcnt  <= '0;
          state <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_sh  <= {rx_sh[6:0], spi_miso};
          end else begin
            sclk_q <= 1'b0;
            if (bcnt == 3'd7) begin
              if (stage == SG_MAIN && x_rd && bidx >= TOT_W'(x_hdr)) begin
                rd_valid <= 1'b1;
                rd_data  <= rx_sh;
              end
              if (stage == SG_POLL) busy_q <= rx_sh[0];
              if (nidx == x_tot) begin
                state <= ST_HOLD;
              end else begin
                tx_sh   <= nxt_byte;
                wr_take <= x_wr && (nidx >= TOT_W'(x_hdr));
                bidx    <= nidx;
                bcnt    <= '0;
              end
            end else begin
              tx_sh <= {tx_sh[6:0], 1'b0};
              bcnt  <= bcnt + 3'd1;
            end
          end
        end
        ST_HOLD: if (tick) state <= ST_GAP;
        ST_GAP: if (tick) begin
          case (stage)
            SG_WEN: begin
              stage <= SG_MAIN;
              state <= ST_SETUP;
            end
            SG_MAIN: begin
              if (writes_flash) begin
                stage <= SG_POLL;
                pcnt  <= '0;
                state <= ST_SETUP;
              end else begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end
            end
            default: begin
              if (!busy_q) begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end else if (POLL_LIMIT != 0 && int'(pcnt) + 1 >= POLL_LIMIT) begin
                done     <= 1'b1;
                err      <= 1'b1;
                err_code <= 2'd2;
                state    <= ST_IDLE;
              end else begin
                pcnt  <= pcnt + POLL_W'(1);
                state <= ST_SETUP;
              end
            end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  assert_mosi_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && !spi_cs_n) |=> (!spi_sclk || $stable(spi_mosi)));
  assert_rd_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !spi_cs_n);
  assert_take_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> !spi_cs_n);
  assert_long_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && bad_len && !bad_op) |=> (done && err && err_code == 2'd1 && spi_cs_n));
  assert_done_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  assert_bad_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && bad_op) |=> (done && err && err_code == 2'd3 && spi_cs_n));
endmodule

// File: tb/spi_nor_sequencer_bench.sv
`timescale 1ns/1ps
module spi_nor_sequencer_bench;
  localparam int LEN_W = 12;
  localparam int POLL  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [7:0] wr_data = '0;
  logic req_ready, wr_take, rd_valid, done, err;
  logic [7:0] rd_data;
  logic [1:0] err_code;
  logic spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  always #10 clk = ~clk;

  spi_nor_sequencer #(.DIV(2), .LEN_W(LEN_W), .PAGE_BYTES(256), .POLL_LIMIT(POLL)) u_spi_nor_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .err(err), .err_code(err_code),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int vec = 0, miss = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural flash model ----------------
  logic [7:0] mem [int];
  bit ersec [int];
  logic [7:0] oplog[$];
  int nlog[$];
  int bitn = 0, bytn = 0, busy_n = 2, busy_left = 0;
  bit wel = 0, p_cs = 1, p_sclk = 0;
  logic [7:0] cmd = 0, sh_in = 0, sh_out = 0;
  logic [23:0] fa = 0, er_addr = 0;

  function automatic logic [7:0] pat(input logic [23:0] a);
    return 8'(a[7:0] * 8'd7 + 8'd3);
  endfunction
  function automatic logic [7:0] frd(input logic [23:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    if (ersec.exists(int'(a >> 12))) return 8'hFF;
    return pat(a);
  endfunction

  always @(spi_cs_n or spi_sclk) begin
    if (!$isunknown(spi_cs_n) && !$isunknown(spi_sclk)) begin
      if (spi_cs_n != p_cs) begin
        if (!spi_cs_n) begin
          bitn = 0; bytn = 0; cmd = 0; sh_out = 0; fa = 0; spi_miso = 1'b0;
        end else begin
          oplog.push_back(cmd);
          nlog.push_back(bytn);
          if (cmd == 8'h06 && bytn == 1) wel = 1;
          else if ((cmd == 8'h02 || cmd == 8'h20) && wel && busy_left == 0) begin
            if (cmd == 8'h20) begin ersec[int'(fa >> 12)] = 1; er_addr = fa; end
            busy_left = busy_n;
            wel = 0;
          end else if (cmd == 8'h05 && busy_left > 0) busy_left--;
        end
      end else if (!spi_cs_n && spi_sclk != p_sclk) begin
        if (spi_sclk) begin
          sh_in = {sh_in[6:0], spi_mosi};
          bitn++;
          if (bitn == 8) begin
            bitn = 0;
            if (bytn == 0) cmd = sh_in;
            else if ((cmd == 8'h02 || cmd == 8'h20 || cmd == 8'h03) && bytn <= 3) fa = {fa[15:0], sh_in};
            else if (cmd == 8'h02) begin
              if (wel && busy_left == 0) mem[int'(fa)] = sh_in;
              fa++;
            end
            bytn++;
          end
        end else begin
          if (bitn == 0) begin
            sh_out = 8'h00;
            if (cmd == 8'h9F) sh_out = (bytn == 1) ? 8'hA5 : (bytn == 2) ? 8'h3C : (bytn == 3) ? 8'h17 : 8'h00;
            else if (cmd == 8'h05) sh_out = {7'b0, busy_left > 0};
            else if (cmd == 8'h03 && bytn >= 4) begin sh_out = frd(fa); fa++; end
          end else sh_out = {sh_out[6:0], 1'b0};
          spi_miso = sh_out[7];
        end
      end
      p_cs = spi_cs_n;
      p_sclk = spi_sclk;
    end
  end

  // ---------------- per-clock reference ----------------
  logic [7:0] rdq[$];
  logic [7:0] wq[$];
  int wptr = 0, ntake = 0;
  bit inflight = 0;

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (done) inflight = 0;
      chk(req_ready == !inflight, "R10", int'(req_ready), int'(!inflight));
      chk(!(spi_cs_n && spi_sclk), "R1", int'(spi_sclk), 0);
      chk(!rd_valid || inflight, "R2", int'(rd_valid), 0);
      if (rd_valid) rdq.push_back(rd_data);
      if (wr_take) begin wptr++; ntake++; end
      if (req_valid && req_ready && req_op <= 3'd4 && !(req_op == 3'd4 && int'(req_len) > 256))
        inflight = 1;
    end
    wr_data = (wptr < wq.size()) ? wq[wptr] : 8'h00;
  end

  bit last_err;
  logic [1:0] last_code;

  task automatic clear_logs();
    oplog.delete(); nlog.delete(); rdq.delete(); ntake = 0;
  endtask

  task automatic run(input logic [2:0] op, input logic [23:0] a, input int n);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = a; req_len = n[LEN_W-1:0]; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    last_err = err; last_code = err_code;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_polls(input int first, input int cnt, input string req);
    for (int i = 0; i < cnt; i++) begin
      chk(oplog[first+i] == 8'h05 && nlog[first+i] == 2, req, int'(oplog[first+i]), 8'h05);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    clear_logs();
    // R12 reset state
    chk(req_ready == 1'b1, "R12", int'(req_ready), 1);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R12", int'({spi_cs_n, spi_sclk}), 2);
    chk(done == 1'b0, "R12", int'(done), 0);

    // R2 identify
    run(3'd0, 24'h0, 0);
    chk(!last_err, "R2", int'(last_err), 0);
    chk(rdq.size() == 3, "R2", rdq.size(), 3);
    if (rdq.size() == 3) begin
      chk(rdq[0] == 8'hA5, "R2", int'(rdq[0]), 8'hA5);
      chk(rdq[1] == 8'h3C, "R2", int'(rdq[1]), 8'h3C);
      chk(rdq[2] == 8'h17, "R2", int'(rdq[2]), 8'h17);
    end
    chk(oplog.size() == 1 && oplog[0] == 8'h9F && nlog[0] == 4, "R2", oplog.size(), 1);
    clear_logs();

    // R3 status
    run(3'd1, 24'h0, 0);
    chk(rdq.size() == 1 && rdq[0] == 8'h00, "R3", rdq.size(), 1);
    chk(oplog.size() == 1 && oplog[0] == 8'h05 && nlog[0] == 2, "R3", oplog.size(), 1);
    clear_logs();

    // R5 + R8 erase with busy polling
    busy_n = 2;
    run(3'd3, 24'h012345, 0);
    chk(!last_err, "R8", int'(last_err), 0);
    chk(oplog.size() == 5, "R8", oplog.size(), 5);
    if (oplog.size() == 5) begin
      chk(oplog[0] == 8'h06 && nlog[0] == 1, "R5", int'(oplog[0]), 8'h06);
      chk(oplog[1] == 8'h20 && nlog[1] == 4, "R5", int'(oplog[1]), 8'h20);
      check_polls(2, 3, "R8");
    end
    chk(er_addr == 24'h012345, "R5", int'(er_addr), 24'h012345);
    clear_logs();

    // R4 read of erased area
    run(3'd2, 24'h012000, 4);
    chk(rdq.size() == 4, "R4", rdq.size(), 4);
    foreach (rdq[i]) chk(rdq[i] == 8'hFF, "R4", int'(rdq[i]), 8'hFF);
    chk(oplog.size() == 1 && oplog[0] == 8'h03 && nlog[0] == 8, "R4", nlog.size(), 1);
    clear_logs();

    // R6 program 5 bytes
    wq = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55}; wptr = 0;
    run(3'd4, 24'h012010, 5);
    chk(!last_err, "R6", int'(last_err), 0);
    chk(ntake == 5, "R6", ntake, 5);
    chk(oplog.size() == 5, "R6", oplog.size(), 5);
    if (oplog.size() == 5) begin
      chk(oplog[0] == 8'h06 && nlog[0] == 1, "R6", int'(oplog[0]), 8'h06);
      chk(oplog[1] == 8'h02 && nlog[1] == 9, "R6", nlog[1], 9);
      check_polls(2, 3, "R8");
    end
    clear_logs();
    run(3'd2, 24'h012010, 5);
    chk(rdq.size() == 5, "R6", rdq.size(), 5);
    foreach (rdq[i]) chk(rdq[i] == wq[i], "R6", int'(rdq[i]), int'(wq[i]));
    clear_logs();

    // R4 read of untouched area, address byte order
    run(3'd2, 24'h00ABC0, 20);
    chk(rdq.size() == 20, "R4", rdq.size(), 20);
    foreach (rdq[i]) chk(rdq[i] == pat(24'h00ABC0 + 24'(i)), "R4", int'(rdq[i]), int'(pat(24'h00ABC0 + 24'(i))));
    clear_logs();

    // R7 too long
    run(3'd4, 24'h013000, 257);
    chk(last_err && last_code == 2'd1, "R7", int'(last_code), 1);
    chk(oplog.size() == 0, "R7", oplog.size(), 0);
    clear_logs();

    // R7 boundary 256 then read back
    wq.delete();
    for (int i = 0; i < 256; i++) wq.push_back(8'(i) ^ 8'h5A);
    wptr = 0;
    run(3'd4, 24'h013000, 256);
    chk(!last_err, "R7", int'(last_err), 0);
    chk(ntake == 256, "R7", ntake, 256);
    chk(nlog.size() > 1 && nlog[1] == 260, "R7", (nlog.size() > 1) ? nlog[1] : 0, 260);
    clear_logs();
    run(3'd2, 24'h013000, 256);
    begin
      int bad = 0;
      foreach (rdq[i]) if (rdq[i] != wq[i]) bad++;
      chk(rdq.size() == 256 && bad == 0, "R7", bad, 0);
    end
    clear_logs();

    // R9 poll timeout
    busy_n = 9;
    run(3'd3, 24'h014000, 0);
    chk(last_err && last_code == 2'd2, "R9", int'(last_code), 2);
    chk(oplog.size() == 2 + POLL, "R9", oplog.size(), 2 + POLL);
    if (oplog.size() == 2 + POLL) check_polls(2, POLL, "R9");
    busy_left = 0;
    busy_n = 2;
    clear_logs();

    // R11 bad request code
    run(3'd6, 24'h0, 0);
    chk(last_err && last_code == 2'd3, "R11", int'(last_code), 3);
    chk(oplog.size() == 0, "R11", oplog.size(), 0);
    clear_logs();

    // R10 request held across completion
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = 3'd1; req_valid = 1'b1;
    @(negedge clk);
    req_op = 3'd0;
    while (!done) @(negedge clk);
    chk(req_ready == 1'b1, "R10", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", int'(req_ready), 0);
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(oplog.size() == 2 && oplog[0] == 8'h05 && oplog[1] == 8'h9F, "R10", oplog.size(), 2);
    chk(rdq.size() == 4 && rdq[0] == 8'h00 && rdq[1] == 8'hA5 && rdq[3] == 8'h17, "R10", rdq.size(), 4);

    summary();
    $finish;
  end
endmodule